// File: doc/BRIEF.md
# Asynchronous Serial Port with Status Flags

This block is a full-duplex asynchronous serial channel with a small register interface. It serialises bytes written by software onto a transmit line, deserialises frames from a receive line into a receive data register, and keeps a set of status flags. The flags cover receive-full, transmit-empty, transmit-end, and sticky per-frame errors for overrun, parity and framing. The receive-full, transmit-empty and transmit-end flags also drive three interrupt request outputs.

A frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and a single high stop bit. The line rests high between frames. Bit timing comes from a fixed clock divisor parameter: one bit lasts `16*CLK_DIV` clock cycles. The receiver oversamples each bit sixteen times and decides at the middle sample. Any error flag halts reception until software has cleared every error flag. Clearing an error flag takes a read of the status register followed by a write of 0. A DMA engine that reads the receive register through its own strobe clears the receive-full flag with that read, so no separate status write is needed.

Register map on `bus_addr`: 0 = line control, 1 = status, 2 = transmit data, 3 = receive data.

Top module: `async_serial_port`

## Requirements
- R1: The transmitter drives `txd` high when idle. Each frame is a 0 start bit, then data bits D0 first through D7, then a parity bit if enabled, then a 1 stop bit. Each bit lasts 16*CLK_DIV clocks.
- R2: Control register bit 0 enables parity and bit 1 selects odd parity (0 = even). With even parity the ones in data plus parity bit total an even number. With odd parity they total an odd number. The same setting applies to transmit and receive.
- R3: A frame received with no error and with receive-full clear loads its byte into the receive data register (address 3). It also sets receive-full (status bit 6) and raises `irq_rx_full`.
- R4: A start bit that is no longer 0 at its mid-point sample is rejected. No byte is loaded and no flag changes.
- R5: A received parity mismatch sets the parity error flag (status bit 3). A 0 sampled in the stop bit sets the framing error flag (status bit 4). An errored byte is not loaded and receive-full stays clear.
- R6: If receive-full is still 1 when the stop bit of a new frame is sampled, the overrun flag (status bit 5) is set. The new byte is discarded and the receive data register keeps the earlier byte.
- R7: While any of overrun, parity or framing error is 1, no new frame is accepted. Reception resumes only after all three are 0.
- R8: An error flag is cleared by writing 0 to its status bit after a status read that returned it as 1. Writing 0 without such a prior read, or writing 1, leaves it set. Writing 0 to status bit 6 clears receive-full.
- R9: A one-cycle pulse on `dma_rx_rd` clears receive-full. `dma_rx_data` always shows the receive data register.
- R10: Status bit 0 reflects the synchronised `rxd` level. After a framing error, a line held at 0 (break) reads as 0.
- R11: Transmit-empty (status bit 7, `irq_tx_empty`) is 1 after reset. A write to address 2 clears it. It returns to 1 when the transmitter takes the byte into its shift register.
- R12: When a stop bit ends with transmit-empty at 1, transmit-end (status bit 2, `irq_tx_end`) is set and `txd` stays 1. If a byte is waiting, its start bit follows at once and transmit-end stays 0. A data write clears transmit-end.
- R13: After reset the status register reads 0x85 with `rxd` high, `txd` is 1 and control is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms error clearing on status reads) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| dma_rx_rd | input | 1 | DMA-side read strobe of the receive register |
| dma_rx_data | output | 8 | Receive data register contents |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_tx_end | output | 1 | Transmit-end interrupt request |

## Verification
The bench targets the sticky-error behaviour. An overrun caused by leaving receive-full set must keep the first byte. A design that overwrote the data or let later frames through would show the wrong receive byte or a fresh receive-full while blocked. A status write of 0 without a prior read must not clear overrun, which catches designs that clear errors on any write. A short low pulse on the line must not turn into a byte, and a break after a framing error must read 0 on the raw line bit. On transmit, back-to-back bytes must leave no idle gap and no transmit-end between frames, and the parity bit must follow the selected sense.

// File: rtl/asp_pkg.sv
package asp_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_TDATA = 2'd2;
    localparam logic [1:0] ADDR_RDATA = 2'd3;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic par_odd;
        logic par_en;
    } line_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_frame_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/asp_baud.sv
module asp_baud #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(CLK_DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  line_cfg_t cfg,
    input  logic      block,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] sh;
    logic              par;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            par   <= 1'b0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: if (!block && !rxd) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: if (cnt == MID) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= rxd ? RX_IDLE : RX_DATA;
                    end else cnt <= cnt + 1'b1;
                    RX_DATA: if (cnt == LAST) begin
                        cnt  <= '0;
                        sh   <= {rxd, sh[DATA_W-1:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == BIT_W'(DATA_W - 1))
                            st <= cfg.par_en ? RX_PAR : RX_STOP;
                    end else cnt <= cnt + 1'b1;
                    RX_PAR: if (cnt == LAST) begin
                        cnt <= '0;
                        par <= rxd;
                        st  <= RX_STOP;
                    end else cnt <= cnt + 1'b1;
                    RX_STOP: if (cnt == LAST) begin
                        cnt        <= '0;
                        st         <= RX_IDLE;
                        done       <= 1'b1;
                        frame.data <= sh;
                        frame.ferr <= !rxd;
                        frame.perr <= cfg.par_en && (par != parity_of(sh, cfg.par_odd));
                    end else cnt <= cnt + 1'b1;
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    AST_RX_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (block && st == RX_IDLE) |=> (st == RX_IDLE)); // R7
endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              have,
    input  logic [DATA_W-1:0] tdr,
    output logic              take,
    output logic              fin,
    output logic              txd
);
    localparam int CNT_W     = $clog2(OVS);
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int NL_W      = $clog2(FRAME_MAX + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    logic                 busy;
    logic [FRAME_MAX-1:0] sh;
    logic [NL_W-1:0]      nleft;
    logic [CNT_W-1:0]     cnt;
    logic [FRAME_MAX-1:0] next_frame;
    logic [NL_W-1:0]      next_len;

    always_comb begin
        next_frame = {1'b1, cfg.par_en ? parity_of(tdr, cfg.par_odd) : 1'b1, tdr, 1'b0};
        next_len   = cfg.par_en ? NL_W'(FRAME_MAX) : NL_W'(FRAME_MAX - 1);
    end

    assign txd = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            sh    <= '1;
            nleft <= '0;
            cnt   <= '0;
            take  <= 1'b0;
            fin   <= 1'b0;
        end else begin
            take <= 1'b0;
            fin  <= 1'b0;
            if (!busy) begin
                if (have) begin
                    sh    <= next_frame;
                    nleft <= next_len;
                    cnt   <= '0;
                    busy  <= 1'b1;
                    take  <= 1'b1;
                end
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt <= '0;
                    if (nleft == NL_W'(1)) begin
                        if (have) begin
                            sh    <= next_frame;
                            nleft <= next_len;
                            take  <= 1'b1;
                        end else begin
                            busy <= 1'b0;
                            fin  <= 1'b1;
                        end
                    end else begin
                        sh    <= {1'b1, sh[FRAME_MAX-1:1]};
                        nleft <= nleft - 1'b1;
                    end
                end else cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd); // R1
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
    import asp_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int OVS     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_rx_rd,
    output logic [DATA_W-1:0] dma_rx_data,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_rx_full,
    output logic              irq_tx_empty,
    output logic              irq_tx_end
);
    logic              tick, rxd_m, rxd_s;
    line_cfg_t         cfg;
    logic              tx_empty, tx_end, rx_full, ovr, fer, per;
    logic [2:0]        arm;
    logic [DATA_W-1:0] rdr, tdr;
    logic              rx_done, take, fin;
    rx_frame_t         rx_frame;
    logic              wr_ctrl, wr_stat, wr_tdat, rd_stat, err_any;

    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_stat = bus_wr && bus_addr == ADDR_STAT;
    assign wr_tdat = bus_wr && bus_addr == ADDR_TDATA;
    assign rd_stat = bus_rd && bus_addr == ADDR_STAT;
    assign err_any = ovr || fer || per;

    asp_baud #(.CLK_DIV(CLK_DIV)) u_baud (.clk(clk), .rst(rst), .tick(tick));

    asp_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd_s), .cfg(cfg),
        .block(err_any), .done(rx_done), .frame(rx_frame)
    );

    asp_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .have(!tx_empty),
        .tdr(tdr), .take(take), .fin(fin), .txd(txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            tx_empty <= 1'b1;
            tx_end   <= 1'b1;
            rx_full  <= 1'b0;
            ovr      <= 1'b0;
            fer      <= 1'b0;
            per      <= 1'b0;
            arm      <= '0;
            rdr      <= '0;
            tdr      <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.par_en  <= bus_wdata[0];
                cfg.par_odd <= bus_wdata[1];
            end
            if (wr_tdat) begin
                tdr      <= bus_wdata;
                tx_empty <= 1'b0;
                tx_end   <= 1'b0;
            end else begin
                if (take) tx_empty <= 1'b1;
                if (fin)  tx_end   <= 1'b1;
            end
            if (rd_stat) arm <= {ovr, fer, per};
            if (wr_stat) begin
                if (!bus_wdata[6]) rx_full <= 1'b0;
                if (arm[2] && !bus_wdata[5]) begin ovr <= 1'b0; arm[2] <= 1'b0; end
                if (arm[1] && !bus_wdata[4]) begin fer <= 1'b0; arm[1] <= 1'b0; end
                if (arm[0] && !bus_wdata[3]) begin per <= 1'b0; arm[0] <= 1'b0; end
            end
            if (dma_rx_rd) rx_full <= 1'b0;
            if (rx_done) begin
                if (rx_full) ovr <= 1'b1;
                else if (rx_frame.ferr || rx_frame.perr) begin
                    if (rx_frame.ferr) fer <= 1'b1;
                    if (rx_frame.perr) per <= 1'b1;
                end else begin
                    rdr     <= rx_frame.data;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = {6'b0, cfg.par_odd, cfg.par_en};
            ADDR_STAT:  bus_rdata = {tx_empty, rx_full, ovr, fer, per, tx_end, 1'b0, rxd_s};
            ADDR_TDATA: bus_rdata = tdr;
            default:    bus_rdata = rdr;
        endcase
    end

    assign dma_rx_data  = rdr;
    assign irq_rx_full  = rx_full;
    assign irq_tx_empty = tx_empty;
    assign irq_tx_end   = tx_end;

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full) |=> (ovr && $stable(rdr))); // R6
    AST_ERR_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr) |-> $past(wr_stat)); // R8
    AST_DMA_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        (dma_rx_rd && !rx_done) |=> !rx_full); // R9
    AST_TXEND_LINE_MARK: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> txd); // R12
    AST_WRITE_FILLS_TDR: assert property (@(posedge clk) disable iff (rst)
        wr_tdat |=> !tx_empty); // R11
endmodule

// File: tb/async_serial_port_bench.sv
module async_serial_port_bench;
    localparam int BIT = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, dma_rx_rd = 1'b0, rxd = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata, dma_rx_data;
    logic       txd, irq_rx_full, irq_tx_empty, irq_tx_end;
    int         total = 0, fails = 0;

    always #10 clk = ~clk;

    async_serial_port u_async_serial_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_rx_rd(dma_rx_rd),
        .dma_rx_data(dma_rx_data), .rxd(rxd), .txd(txd), .irq_rx_full(irq_rx_full),
        .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end)
    );

    // data, par_en, par_odd, bad_par, stop, exp_full, exp_perr, exp_ferr
    localparam logic [14:0] VEC [0:5] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h3D, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                              input logic badp, input logic stopv);
        @(negedge clk);
        rxd = 1'b0; repeat (BIT) @(negedge clk);
        for (int b = 0; b < 8; b++) begin rxd = d[b]; repeat (BIT) @(negedge clk); end
        if (pen) begin rxd = (^d) ^ podd ^ badp; repeat (BIT) @(negedge clk); end
        rxd = stopv; repeat (BIT) @(negedge clk);
    endtask

    task automatic idle_after(input int n);
        rxd = 1'b1; repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        logic [7:0] s;
        bus_read(2'd1, s);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic capture(input int nbits, output logic [10:0] bits);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        bits = '0;
        bits[0] = txd;
        for (int b = 1; b <= nbits; b++) begin
            repeat (BIT) @(negedge clk);
            bits[b] = txd;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0]  s, d;
        logic [10:0] fr;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R13 reset state
        bus_read(2'd1, s);
        chk("R13 status after reset", s, 8'h85);
        chk("R13 txd idle", txd, 1'b1);
        bus_read(2'd0, s);
        chk("R13 control after reset", s, 8'h00);
        chk("R11 irq_tx_empty after reset", irq_tx_empty, 1'b1);

        // R3 R2 R5 table of frames
        for (int i = 0; i < 6; i++) begin
            logic [14:0] v;
            v = VEC[i];
            bus_write(2'd0, {6'b0, v[5], v[6]});
            send_frame(v[14:7], v[6], v[5], v[4], v[3]);
            idle_after(16);
            bus_read(2'd1, s);
            chk($sformatf("R3 vec%0d rx_full", i), s[6], v[2]);
            chk($sformatf("R5 vec%0d parity err", i), s[3], v[1]);
            chk($sformatf("R5 vec%0d framing err", i), s[4], v[0]);
            if (v[2]) begin
                bus_read(2'd3, d);
                chk($sformatf("R3 vec%0d rx data", i), d, {24'b0, v[14:7]});
            end
            bus_write(2'd1, 8'h00);
            bus_read(2'd1, s);
            chk($sformatf("R8 vec%0d flags cleared", i), s & 8'h78, 8'h00);
        end

        // R4 glitch on the line
        bus_write(2'd0, 8'h00);
        @(negedge clk); rxd = 1'b0;
        repeat (12) @(negedge clk);
        idle_after(800);
        bus_read(2'd1, s);
        chk("R4 glitch ignored", s & 8'h78, 8'h00);

        // R6 R7 R8 overrun and blocking
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_after(16);
        bus_read(2'd1, s);
        chk("R3 first byte full", s[6], 1'b1);
        send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_after(16);
        bus_read(2'd3, d);
        chk("R6 earlier byte kept", d, 8'h11);
        bus_write(2'd1, 8'h00);
        chk("R8 rx_full cleared by write", irq_rx_full, 1'b0);
        bus_read(2'd1, s);
        chk("R8 overrun kept without read", s[5], 1'b1);
        send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_after(16);
        bus_read(2'd1, s);
        chk("R7 blocked frame not taken", s[6], 1'b0);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, s);
        chk("R8 write of 1 leaves overrun", s[5], 1'b1);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, s);
        chk("R8 overrun cleared after read", s[5], 1'b0);
        send_frame(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_after(16);
        bus_read(2'd3, d);
        chk("R7 reception resumes", d, 8'h44);

        // R9 DMA read clears
        bus_write(2'd1, 8'h00);
        send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_after(16);
        chk("R3 irq_rx_full raised", irq_rx_full, 1'b1);
        chk("R9 dma data", dma_rx_data, 8'h55);
        @(negedge clk); dma_rx_rd = 1'b1;
        @(negedge clk); dma_rx_rd = 1'b0;
        @(negedge clk);
        chk("R9 dma read clears full", irq_rx_full, 1'b0);

        // R10 break after framing error
        send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        bus_read(2'd1, s);
        chk("R10 framing on break", s[4], 1'b1);
        chk("R10 raw line low", s[0], 1'b0);
        idle_after(16);
        clear_all();

        // R1 R2 R11 R12 transmit with even parity
        bus_write(2'd0, 8'h01);
        bus_write(2'd2, 8'hC3);
        repeat (5) @(negedge clk);
        bus_read(2'd1, s);
        chk("R11 tx_empty back after take", s[7], 1'b1);
        chk("R12 tx_end cleared by write", s[2], 1'b0);
        capture(10, fr);
        chk("R1 tx start bit", fr[0], 1'b0);
        chk("R1 tx data lsb first", fr[8:1], 8'hC3);
        chk("R2 tx even parity", fr[9], ^8'hC3);
        chk("R1 tx stop bit", fr[10], 1'b1);
        repeat (BIT) @(negedge clk);
        chk("R12 tx_end after frame", irq_tx_end, 1'b1);
        chk("R12 line high after frame", txd, 1'b1);

        // R12 back-to-back without parity
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h5A);
        repeat (5) @(negedge clk);
        bus_write(2'd2, 8'hA6);
        capture(9, fr);
        chk("R1 first frame data", fr[8:1], 8'h5A);
        chk("R12 no tx_end between frames", irq_tx_end, 1'b0);
        repeat (BIT / 2 + 2) @(negedge clk);
        chk("R12 next start follows at once", txd, 1'b0);
        capture(9, fr);
        chk("R1 second frame data", fr[8:1], 8'hA6);
        repeat (BIT) @(negedge clk);
        chk("R12 tx_end after last frame", irq_tx_end, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule